// File: doc/BRIEF.md
# AXI4-Stream Packet Receiver into a Byte FIFO

This block terminates one AXI4-Stream input and writes the valid bytes of a single packet into a byte-granular FIFO. Each accepted beat is held for one cycle in a buffer register. Its valid byte count, taken from the strobes, is turned into a push size. The buffered beat is then written to the FIFO while the next beat is already being accepted, so a packet can stream at one beat per clock.

The FIFO reports how many bytes it can take. That figure does not allow for a push in the same cycle, so the receiver keeps streaming only while two full beats would fit. When room runs short it holds the pending beat, drops `s_tready` and raises `st_wait`. The end of a packet has its own path. A final beat with no valid bytes is accepted and dropped. A final beat that does not fit waits for exactly its own byte count.

A controlling unit arms the block with `ctl_start` and sees `st_finish` at the end of the packet. It can abandon a stalled packet with `ctl_flush`, and the block then swallows the rest of the stream. `ctl_rearm` returns the block to its reset state, which clears the FIFO for the next packet.

Top module: `axis_pack_rx`

## Requirements
- R1: While `rst_n` is low, the block is in its reset state. In that state `fifo_clear_req` is high and `s_tready` and `fifo_push_req` are low. Once `rst_n` is high and `ctl_rearm` is low, the block leaves that state on the next clock edge.
- R2: In the idle state `st_no_data` is high and `s_tready` is low, so beats offered before `ctl_start` are not taken. After a `ctl_start` pulse, `s_tready` and `st_no_data` are both high. At most one of `st_no_data`, `st_wait` and `st_finish` is high at any time.
- R3: The strobes of a beat are contiguous from lane 0. Each stored beat is pushed with `fifo_push_size` equal to the number of set `s_tstrb` bits minus one. Byte lane k of `fifo_push_data` is TDATA bits 8k+7..8k. The FIFO receives exactly the packet's valid bytes, in stream order, with none lost or duplicated.
- R4: A push never asks for more bytes than `fifo_free_bytes` reports in that cycle.
- R5: While the FIFO keeps at least two beats of room, the block accepts one beat on every cycle that `s_tvalid` is high and never drops `s_tready`.
- R6: If a non-last beat is accepted when room is short, it is held with `s_tready` low and `st_wait` high. Room is short when under two beats are free in the same cycle as a push, or under one beat otherwise. The block resumes once at least one beat of room is free, and no data is lost.
- R7: A last beat with valid bytes is stored at once when room allows. Otherwise `st_wait` stays high until `fifo_free_bytes` is at least its valid byte count. The beat is then pushed and `st_finish` follows.
- R8: A last beat whose `s_tstrb` is all zero is accepted but not pushed, and `st_finish` rises on the next cycle.
- R9: `ctl_flush` while a non-last beat is held discards that beat and every later beat of the packet. During this `s_tready` stays high and nothing is pushed. After the beat with TLAST, `st_finish` rises.
- R10: `st_finish` holds until `ctl_rearm`. The block then enters its reset state, raising `fifo_clear_req`, and returns to idle once `ctl_rearm` is low.
- R11: Gaps in `s_tvalid` inside a packet keep `s_tready` high. No beat is stalled or repeated because of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat ready |
| s_tdata | input | 8*BUS_BYTES | Stream beat data |
| s_tstrb | input | BUS_BYTES | Per-lane byte-valid strobes, contiguous from lane 0 |
| s_tlast | input | 1 | Last beat of the packet |
| fifo_push_req | output | 1 | Write the buffered beat into the FIFO |
| fifo_push_size | output | clog2(BUS_BYTES) | Bytes to write minus one |
| fifo_push_data | output | 8*BUS_BYTES | Buffered beat, valid bytes in the low lanes |
| fifo_free_bytes | input | FREE_W | Bytes the FIFO can still accept |
| fifo_clear_req | output | 1 | Synchronous FIFO clear |
| ctl_start | input | 1 | Arm the receiver for a packet |
| ctl_flush | input | 1 | Abandon a stalled packet |
| ctl_rearm | input | 1 | Return from finish to the reset state |
| st_no_data | output | 1 | Packet not yet started |
| st_wait | output | 1 | Reception blocked by a full FIFO |
| st_finish | output | 1 | Packet fully handled |

## Verification
The bench builds the block with four byte lanes and drives it from a FIFO model holding only twelve bytes. At that size a three-beat backlog fills the FIFO, so every stall path is reachable: the streaming stall, the last-beat stall and the stall before a flush. The bench sweeps packet length, last-beat byte count from zero to four, gap length between beats and FIFO drain rate. For each packet it checks the stored bytes against a value computed from the packet, beat and lane numbers. Directed packets with a frozen drain force the wait, last-beat-wait and flush states on chosen beats.

// File: rtl/axis_pack_rx_pkg.sv
package axis_pack_rx_pkg;

    // Receiver control states
    typedef enum logic [3:0] {
        ST_RESET,       // clearing the FIFO
        ST_IDLE,        // waiting to be armed
        ST_ARMED,       // ready, no beat seen yet
        ST_STREAM,      // pushing held beat while accepting the next
        ST_GAP,         // source paused mid-packet
        ST_STALL,       // non-last beat held, FIFO short of room
        ST_TAIL,        // pushing the last beat
        ST_TAIL_STALL,  // last beat held, FIFO short of room
        ST_DONE,        // packet complete
        ST_DRAIN        // discarding the rest of an abandoned packet
    } rx_state_e;

endpackage

// File: rtl/apr_lane_count.sv
module apr_lane_count #(
    parameter int BUS_BYTES = 4,
    parameter int CNT_W     = 3
) (
    input  logic [BUS_BYTES-1:0] strb,
    output logic [CNT_W-1:0]     count
);

    // Strobes are packed from lane 0, so a ones count is the byte count.
    always_comb begin
        count = '0;
        for (int i = 0; i < BUS_BYTES; i++) begin
            count = count + CNT_W'(strb[i]);
        end
    end

endmodule

// File: rtl/apr_room_eval.sv
module apr_room_eval #(
    parameter int BUS_BYTES = 4,
    parameter int FREE_W    = 8,
    parameter int CNT_W     = 3
) (
    input  logic [FREE_W-1:0] free_bytes,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic [CNT_W-1:0]  held_cnt,
    output logic              room_one,
    output logic              room_two,
    output logic              room_live,
    output logic              room_held
);

    localparam int ONE_BEAT = BUS_BYTES;
    localparam int TWO_BEAT = 2 * BUS_BYTES;

    assign room_one  = 32'(free_bytes) >= 32'(ONE_BEAT);
    assign room_two  = 32'(free_bytes) >= 32'(TWO_BEAT);
    assign room_live = 32'(free_bytes) >= 32'(live_cnt);
    assign room_held = 32'(free_bytes) >= 32'(held_cnt);

endmodule

// File: rtl/axis_pack_rx.sv
module axis_pack_rx
    import axis_pack_rx_pkg::*;
#(
    parameter  int BUS_BYTES = 4,
    parameter  int FREE_W    = 8,
    localparam int DATA_W    = 8 * BUS_BYTES,
    localparam int SIZE_W    = $clog2(BUS_BYTES),
    localparam int CNT_W     = $clog2(BUS_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic [BUS_BYTES-1:0] s_tstrb,
    input  logic              s_tlast,
    output logic              fifo_push_req,
    output logic [SIZE_W-1:0] fifo_push_size,
    output logic [DATA_W-1:0] fifo_push_data,
    input  logic [FREE_W-1:0] fifo_free_bytes,
    output logic              fifo_clear_req,
    input  logic              ctl_start,
    input  logic              ctl_flush,
    input  logic              ctl_rearm,
    output logic              st_no_data,
    output logic              st_wait,
    output logic              st_finish
);

    typedef struct packed {
        rx_state_e         st;
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
    } rx_regs_t;

    rx_regs_t r_q, r_d;

    logic [CNT_W-1:0] beat_cnt;
    logic [CNT_W-1:0] cnt_m1;
    logic             buf_en;
    logic             room_one, room_two, room_live, room_held;
    rx_state_e        cur_st;

    apr_lane_count #(
        .BUS_BYTES (BUS_BYTES),
        .CNT_W     (CNT_W)
    ) u_count (
        .strb  (s_tstrb),
        .count (beat_cnt)
    );

    apr_room_eval #(
        .BUS_BYTES (BUS_BYTES),
        .FREE_W    (FREE_W),
        .CNT_W     (CNT_W)
    ) u_room (
        .free_bytes (fifo_free_bytes),
        .live_cnt   (beat_cnt),
        .held_cnt   (r_q.cnt),
        .room_one   (room_one),
        .room_two   (room_two),
        .room_live  (room_live),
        .room_held  (room_held)
    );

    assign cur_st         = r_q.st;
    assign cnt_m1         = r_q.cnt - CNT_W'(1);
    assign fifo_push_size = cnt_m1[SIZE_W-1:0];
    assign fifo_push_data = r_q.data;

    always_comb begin
        r_d            = r_q;
        s_tready       = 1'b0;
        buf_en         = 1'b0;
        fifo_push_req  = 1'b0;
        fifo_clear_req = 1'b0;
        st_no_data     = 1'b0;
        st_wait        = 1'b0;
        st_finish      = 1'b0;

        unique case (r_q.st)
            ST_RESET: begin
                fifo_clear_req = 1'b1;
                if (!ctl_rearm) r_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                st_no_data = 1'b1;
                if (ctl_start) r_d.st = ST_ARMED;
            end
            ST_ARMED, ST_GAP: begin
                // data may land in the same cycle TVALID rises
                s_tready   = 1'b1;
                buf_en     = 1'b1;
                st_no_data = (r_q.st == ST_ARMED);
                if (s_tvalid) begin
                    if (s_tlast) begin
                        if (beat_cnt == '0)  r_d.st = ST_DONE;
                        else if (room_live)  r_d.st = ST_TAIL;
                        else                 r_d.st = ST_TAIL_STALL;
                    end else if (room_one) begin
                        r_d.st = ST_STREAM;
                    end else begin
                        r_d.st = ST_STALL;
                    end
                end
            end
            ST_STREAM: begin
                // free_bytes ignores this push, hence the two-beat margin
                s_tready      = 1'b1;
                buf_en        = 1'b1;
                fifo_push_req = 1'b1;
                if (!s_tvalid) begin
                    r_d.st = ST_GAP;
                end else if (s_tlast) begin
                    if (beat_cnt == '0)  r_d.st = ST_DONE;
                    else if (room_two)   r_d.st = ST_TAIL;
                    else                 r_d.st = ST_TAIL_STALL;
                end else if (room_two) begin
                    r_d.st = ST_STREAM;
                end else begin
                    r_d.st = ST_STALL;
                end
            end
            ST_STALL: begin
                st_wait = 1'b1;
                if (ctl_flush)     r_d.st = ST_DRAIN;
                else if (room_one) r_d.st = ST_STREAM;
            end
            ST_TAIL_STALL: begin
                st_wait = 1'b1;
                if (room_held) r_d.st = ST_TAIL;
            end
            ST_TAIL: begin
                fifo_push_req = 1'b1;
                r_d.st        = ST_DONE;
            end
            ST_DONE: begin
                st_finish = 1'b1;
                if (ctl_rearm) r_d.st = ST_RESET;
            end
            ST_DRAIN: begin
                s_tready = 1'b1;
                if (s_tvalid && s_tlast) r_d.st = ST_DONE;
            end
            default: r_d.st = ST_RESET;
        endcase

        if (buf_en && s_tvalid) begin
            r_d.data = s_tdata;
            r_d.cnt  = beat_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RESET, data: '0, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/axis_pack_rx_chk.sv
module axis_pack_rx_chk
    import axis_pack_rx_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    parameter int FREE_W    = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         s_tvalid,
    input logic                         s_tready,
    input logic                         s_tlast,
    input logic [BUS_BYTES-1:0]         s_tstrb,
    input logic                         fifo_push_req,
    input logic [$clog2(BUS_BYTES)-1:0] fifo_push_size,
    input logic [FREE_W-1:0]            fifo_free_bytes,
    input logic                         fifo_clear_req,
    input logic                         ctl_start,
    input logic                         ctl_flush,
    input logic                         ctl_rearm,
    input logic                         st_no_data,
    input logic                         st_wait,
    input logic                         st_finish,
    input rx_state_e                    state
);

    a_r1_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear_req |-> !s_tready && !fifo_push_req && !st_no_data);

    a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
        st_no_data && !s_tready && ctl_start |=> s_tready && st_no_data);

    a_r2_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_no_data, st_wait, st_finish}));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push_req |-> 32'(fifo_free_bytes) >= 32'(fifo_push_size) + 32'd1);

    a_r6_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        st_wait |-> !s_tready && !fifo_push_req);

    a_r8_empty_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED || state == ST_GAP) && s_tvalid && s_tlast && s_tstrb == '0
        |=> st_finish && !fifo_push_req);

    a_r9_flush_enters: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_STALL && ctl_flush |=> s_tready && !st_wait && !fifo_push_req);

    a_r9_drain_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DRAIN |-> s_tready && !fifo_push_req);

    a_r10_finish_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st_finish && !ctl_rearm |=> st_finish);

    a_r10_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        st_finish && ctl_rearm |=> fifo_clear_req);

endmodule

bind axis_pack_rx axis_pack_rx_chk #(
    .BUS_BYTES (BUS_BYTES),
    .FREE_W    (FREE_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .s_tvalid        (s_tvalid),
    .s_tready        (s_tready),
    .s_tlast         (s_tlast),
    .s_tstrb         (s_tstrb),
    .fifo_push_req   (fifo_push_req),
    .fifo_push_size  (fifo_push_size),
    .fifo_free_bytes (fifo_free_bytes),
    .fifo_clear_req  (fifo_clear_req),
    .ctl_start       (ctl_start),
    .ctl_flush       (ctl_flush),
    .ctl_rearm       (ctl_rearm),
    .st_no_data      (st_no_data),
    .st_wait         (st_wait),
    .st_finish       (st_finish),
    .state           (cur_st)
);

// File: tb/axis_pack_rx_test.sv
module axis_pack_rx_test;

    localparam int BB  = 4;
    localparam int FW  = 8;
    localparam int CAP = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              s_tvalid = 1'b0;
    logic              s_tready;
    logic [8*BB-1:0]   s_tdata = '0;
    logic [BB-1:0]     s_tstrb = '0;
    logic              s_tlast = 1'b0;
    logic              fifo_push_req;
    logic [1:0]        fifo_push_size;
    logic [8*BB-1:0]   fifo_push_data;
    logic [FW-1:0]     fifo_free_bytes;
    logic              fifo_clear_req;
    logic              ctl_start = 1'b0;
    logic              ctl_flush = 1'b0;
    logic              ctl_rearm = 1'b0;
    logic              st_no_data;
    logic              st_wait;
    logic              st_finish;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    axis_pack_rx #(.BUS_BYTES(BB), .FREE_W(FW)) uut (
        .clk(clk), .rst_n(rst_n),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
        .s_tstrb(s_tstrb), .s_tlast(s_tlast),
        .fifo_push_req(fifo_push_req), .fifo_push_size(fifo_push_size),
        .fifo_push_data(fifo_push_data), .fifo_free_bytes(fifo_free_bytes),
        .fifo_clear_req(fifo_clear_req),
        .ctl_start(ctl_start), .ctl_flush(ctl_flush), .ctl_rearm(ctl_rearm),
        .st_no_data(st_no_data), .st_wait(st_wait), .st_finish(st_finish)
    );

    // FIFO model: byte occupancy, a drain rate and a log of every pushed byte
    int          fcnt = 0;
    int          drain_rate = 4;
    int          log_n = 0;
    int          ovf_n = 0;
    logic [7:0]  log_mem [0:8191];

    assign fifo_free_bytes = FW'(CAP - fcnt);

    always @(posedge clk) begin
        int pop_n;
        int push_n;
        if (fifo_clear_req) begin
            fcnt <= 0;
        end else begin
            pop_n  = (drain_rate < fcnt) ? drain_rate : fcnt;
            push_n = fifo_push_req ? int'(fifo_push_size) + 1 : 0;
            if (push_n > CAP - fcnt) ovf_n <= ovf_n + 1;
            for (int k = 0; k < BB; k++)
                if (k < push_n) log_mem[log_n + k] <= fifo_push_data[8*k +: 8];
            log_n <= log_n + push_n;
            fcnt  <= fcnt + push_n - pop_n;
        end
    end

    // Monotonic monitors, read as differences by the tasks
    int stall_n = 0;
    int wait_n  = 0;
    int viol_n  = 0;
    always @(negedge clk) begin
        if (s_tvalid && !s_tready && !st_wait && uut.cur_st != axis_pack_rx_pkg::ST_IDLE)
            stall_n <= stall_n + 1;
        if (s_tvalid && st_wait) stall_n <= stall_n + 1;
        if (st_wait) wait_n <= wait_n + 1;
        if (st_wait && s_tready) viol_n <= viol_n + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input int p, input int b, input int l);
        return 8'((p * 53 + b * 7 + l * 29 + 1) & 255);
    endfunction

    task automatic send_pkt(input int pid, input int nb, input int lastcnt, input int gap);
        bit acc;
        for (int b = 0; b < nb; b++) begin
            int nbytes;
            nbytes   = (b == nb - 1) ? lastcnt : BB;
            s_tvalid = 1'b1;
            s_tlast  = (b == nb - 1);
            for (int l = 0; l < BB; l++) begin
                s_tdata[8*l +: 8] = (l < nbytes) ? bval(pid, b, l) : 8'hEE;
                s_tstrb[l]        = (l < nbytes);
            end
            do begin
                acc = s_tready;
                @(negedge clk);
            end while (!acc);
            s_tvalid = 1'b0;
            s_tlast  = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    // mode 0: plain; 1: release a frozen drain after a stall; 2: flush on stall
    task automatic run_pkt(input int pid, input int nb, input int lastcnt, input int gap,
                           input int rate, input int mode, input int exp_n, input string req);
        int base, st0, w0, v0, mism, t, got;
        drain_rate = rate;
        base = log_n; st0 = stall_n; w0 = wait_n; v0 = viol_n;
        ctl_start = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0;
        chk(s_tready && st_no_data, "R2", "armed ready", int'(s_tready), 1);
        fork
            send_pkt(pid, nb, lastcnt, gap);
            if (mode != 0) begin
                t = 0;
                while (!st_wait && t < 200) begin @(negedge clk); t++; end
                if (mode == 2) begin
                    ctl_flush = 1'b1;
                    @(negedge clk);
                    ctl_flush = 1'b0;
                end else begin
                    repeat (3) @(negedge clk);
                    drain_rate = 4;
                end
            end
        join
        t = 0;
        while (!st_finish && t < 400) begin @(negedge clk); t++; end
        chk(st_finish == 1'b1, "R10", "finish reached", int'(st_finish), 1);
        got = log_n - base;
        chk(got == exp_n, req, "stored byte count", got, exp_n);
        mism = 0;
        for (int i = 0; i < got && i < exp_n; i++)
            if (log_mem[base + i] != bval(pid, i / BB, i % BB)) mism++;
        chk(mism == 0, "R3", "byte order/content mismatches", mism, 0);
        chk(viol_n == v0, "R6", "tready high while waiting", viol_n - v0, 0);
        if (rate >= 4 && mode == 0)
            chk(stall_n == st0, "R5", "stalled cycles with ample room (R11 gaps)", stall_n - st0, 0);
        if (mode != 0)
            chk(wait_n > w0, req, "wait seen", wait_n - w0, 1);
        repeat (2) @(negedge clk);
        chk(st_finish == 1'b1 && !st_wait && !st_no_data, "R10", "finish held",
            int'(st_finish), 1);
        ctl_rearm = 1'b1;
        @(negedge clk);
        ctl_rearm = 1'b0;
        chk(fifo_clear_req == 1'b1, "R10", "clear after rearm", int'(fifo_clear_req), 1);
        @(negedge clk);
        chk(st_no_data && !fifo_clear_req, "R10", "idle after rearm", int'(st_no_data), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;
        int pid;
        repeat (3) @(negedge clk);
        chk(fifo_clear_req && !s_tready && !fifo_push_req, "R1", "reset outputs",
            int'(fifo_clear_req), 1);
        rst_n = 1'b1;
        #1;
        chk(fifo_clear_req == 1'b1, "R1", "clear until first edge", int'(fifo_clear_req), 1);
        @(negedge clk);
        chk(st_no_data && !fifo_clear_req && !s_tready, "R1", "idle after reset",
            int'(st_no_data), 1);

        // Beats offered while idle are not taken
        base = log_n;
        s_tvalid = 1'b1; s_tlast = 1'b1; s_tstrb = '1; s_tdata = 32'h11223344;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(s_tready == 1'b0, "R2", "tready low in idle", int'(s_tready), 0);
        end
        s_tvalid = 1'b0; s_tlast = 1'b0;
        chk(log_n == base, "R2", "no push while idle", log_n - base, 0);

        pid = 1;
        // Empty last beat as the only beat
        run_pkt(pid++, 1, 0, 0, 4, 0, 0, "R8");
        // Stall on a middle beat, then resume
        run_pkt(pid++, 6, 4, 0, 0, 1, 24, "R6");
        // Stall on the last beat, waits for its own 3 bytes
        run_pkt(pid++, 4, 3, 0, 0, 1, 15, "R7");
        // Flush while stalled: only the first three beats survive
        run_pkt(pid++, 6, 4, 0, 0, 2, 12, "R9");

        // Sweep of length, tail bytes, gaps and drain rate
        for (int nb = 1; nb <= 4; nb++)
            for (int lc = 0; lc <= BB; lc++)
                for (int g = 0; g <= 2; g++)
                    for (int r = 0; r < 3; r++) begin
                        int rate;
                        rate = (r == 0) ? 1 : (r == 1) ? 2 : 4;
                        run_pkt(pid++, nb, lc, g, rate, 0, (nb - 1) * BB + lc,
                                (lc == 0) ? "R8" : (g > 0) ? "R11" : "R7");
                    end

        chk(ovf_n == 0, "R4", "pushes beyond free bytes", ovf_n, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule